// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Generator

This block drives a bank of pulse-width-modulated outputs that all run on one common period. A programmable 8-bit prescaler divides the system clock down to a local tick. A shared 8-bit counter steps once per tick, so one period is always 256 ticks long, and the prescaler is the only thing that sets the period. Each channel compares the shared counter against its own 8-bit duty value. A duty value N holds the output high for N+1 ticks at the start of each period.

Software reaches the block through a simple write/read register port. One word holds each channel's duty value. A control word holds the prescaler and a common enable. The prescaler is stored as two 4-bit fields that are not next to each other in the control word. A new duty value is held in a pending copy and only goes live at the next counter wrap, so a running period is never cut short. While the enable is clear, every output is low and the whole timebase stays at zero. Setting the enable again therefore always starts a fresh period.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every output is low, every duty register reads 0 and the control word reads 0.
- R2: While enabled, the shared counter advances by one every (prescale+1) clock cycles and wraps from 255 to 0, so a period lasts 256*(prescale+1) cycles.
- R3: Prescale bits [3:0] come from control bits 3:0 and prescale bits [7:4] come from control bits 14:11.
- R4: With duty N, an output is high while the counter is at most N: value 0 gives a single high tick, and value 255 keeps the output high for the whole period.
- R5: Channel x's duty register sits at byte offset 4*x and reads back in bits 7:0. The control word sits at offset 0x50.
- R6: Control bit 9 is the common enable. While it is 0, all outputs are low and the prescale divider and the counter are held at 0. On re-enable, counting restarts at counter value 0.
- R7: A duty write made while the block is enabled takes effect only at the next counter wrap. A duty write made while the block is disabled is live at once.
- R8: Writes to offsets that map to no register change nothing. Control bits other than 3:0, 9 and 14:11 are not stored and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 7 | Byte offset of the register to write or read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The bench builds the block with its defaults: four channels and an 8-bit counter. It programs small prescale values (0, 1 and 18), which keeps a full period between 256 and 4864 cycles. Every output can then be compared cycle by cycle against an arithmetic model across whole periods, including both duty extremes. Prescale 18 places a nonzero value in both nibble fields. A duty write made partway through a period shows the deferred update across the wrap. A disable made in the middle of a period, followed by a re-enable, shows that the timebase restarts from zero.

// File: rtl/pwm_bank_pkg.sv
// Package: register layout constants shared by the PWM bank modules.
// Assumes byte addressing with word-aligned registers.
package pwm_bank_pkg;
    localparam int ADDR_W      = 7;
    localparam int DATA_W      = 32;
    localparam int NIB_W       = 4;
    localparam int PS_W        = 2 * NIB_W;
    localparam int DUTY_STRIDE = 4;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 7'h50;
    localparam int EN_BIT      = 9;
    localparam int PS_LO_LSB   = 0;
    localparam int PS_HI_LSB   = 11;
endpackage

// File: rtl/pwm_regs.sv
// Register file: one duty word per channel plus the control word.
// The control word holds the split prescaler and the common enable.
// Assumes writes are single-cycle strobes. Reads are combinational on the address.
module pwm_regs
    import pwm_bank_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic [NCH-1:0][CNT_W-1:0] duty_pend,
    output logic [PS_W-1:0]           ps,
    output logic                      en
);
    logic [NIB_W-1:0] ps_lo, ps_hi;
    logic             ctrl_hit;

    assign ctrl_hit = bus_wr && (bus_addr == CTRL_ADDR);
    assign ps       = {ps_hi, ps_lo};

    // Duty registers: load the matching word on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_pend <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (bus_wr && (bus_addr == ADDR_W'(DUTY_STRIDE * i)))
                    duty_pend[i] <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    // Control word: capture only the prescale nibbles and the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_lo <= '0;
            ps_hi <= '0;
            en    <= 1'b0;
        end else if (ctrl_hit) begin
            ps_lo <= bus_wdata[PS_LO_LSB +: NIB_W];
            ps_hi <= bus_wdata[PS_HI_LSB +: NIB_W];
            en    <= bus_wdata[EN_BIT];
        end
    end

    // Read mux: return the stored fields at their bit positions.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ADDR_W'(DUTY_STRIDE * i))
                bus_rdata[CNT_W-1:0] = duty_pend[i];
        end
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata[PS_LO_LSB +: NIB_W] = ps_lo;
            bus_rdata[PS_HI_LSB +: NIB_W] = ps_hi;
            bus_rdata[EN_BIT]             = en;
        end
    end

    // Any cycle without a control write leaves the control fields unchanged.
    p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_hit |=> $stable({ps, en}));
endmodule

// File: rtl/pwm_timebase.sv
// Timebase: the prescale divider and the shared period counter.
// The counter steps once every (ps+1) clocks and wraps from all-ones to 0.
// Assumes ps stays constant while en is high. Both registers are held at 0 while en is low.
module pwm_timebase #(
    parameter int CNT_W = 8,
    parameter int PS_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PS_W-1:0]  ps,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [PS_W-1:0] div;
    logic            tick;

    assign tick = (div == ps);
    assign wrap = en && tick && (cnt == '1);

    // Divider and counter: clear when disabled, step the counter on each divider rollover.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            div <= '0;
            cnt <= '0;
        end else if (tick) begin
            div <= '0;
            cnt <= cnt + 1'b1;
        end else begin
            div <= div + 1'b1;
        end
    end

    // A cycle with the enable low leaves the timebase at zero.
    p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0) && (div == '0));
    // A local tick advances the counter by exactly one, with wrap.
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
    // Between ticks the counter holds.
    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(cnt));
endmodule

// File: rtl/pwm_chan.sv
// One PWM channel: keeps a live copy of the duty value and compares it with the shared counter.
// The live copy follows the pending value while disabled, and reloads only at a wrap while enabled.
module pwm_chan #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wrap,
    input  logic [CNT_W-1:0] duty_pend,
    input  logic [CNT_W-1:0] cnt,
    output logic             out
);
    logic [CNT_W-1:0] act;

    // Live duty: reload at a period boundary or whenever the block is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act <= '0;
        else if (!en || wrap)
            act <= duty_pend;
    end

    // High for counter values 0..act, so the pulse lasts act+1 ticks.
    assign out = en && (cnt <= act);

    // Within a running period the live duty never changes.
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wrap) |=> $stable(act));
    // Every enabled period begins with the output high.
    p_start_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (cnt == '0)) |-> out);
endmodule

// File: rtl/pwm_bank.sv
// Top level of the shared-period PWM bank: register file, one timebase and NCH channels.
// Assumes a single clock domain. Outputs are combinational from registered state.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    logic [NCH-1:0][CNT_W-1:0] duty_pend;
    logic [PS_W-1:0]           ps;
    logic                      en;
    logic [CNT_W-1:0]          cnt;
    logic                      wrap;

    pwm_regs #(.NCH(NCH), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .duty_pend(duty_pend), .ps(ps), .en(en)
    );

    pwm_timebase #(.CNT_W(CNT_W), .PS_W(PS_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .en(en), .ps(ps), .cnt(cnt), .wrap(wrap)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_chan #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .en(en), .wrap(wrap),
            .duty_pend(duty_pend[g]), .cnt(cnt), .out(pwm_out[g])
        );
    end

    // With the enable clear, no channel drives high.
    p_out_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (pwm_out == '0));
endmodule

// File: tb/tb_pwm_bank.sv
`timescale 1ns/1ps
module tb_pwm_bank;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] pwm_out;

    int errors = 0;
    int checks = 0;

    pwm_bank #(.NCH(NCH), .CNT_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Write one register. Returns at the falling edge after the write edge.
    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input int ps, input bit en);
        return (32'(ps & 15)) | (32'((ps >> 4) & 15) << 11) | (32'(en) << 9);
    endfunction

    // Load duties while disabled, enable with prescale ps, and compare every cycle over nper periods.
    // If chg is set, channel 0 gets duty newd written at cycle 5 of the first period.
    task automatic run_cfg(input string req, input int ps, input int d0, input int d1,
                           input int d2, input int d3, input int nper,
                           input bit chg, input int newd);
        int d[4];
        int per_len;
        d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
        per_len = 256 * (ps + 1);
        for (int c = 0; c < NCH; c++) wr(7'(4 * c), 32'(d[c]));
        wr(7'h50, ctrl_word(ps, 1'b1));
        for (int k = 0; k < nper * per_len; k++) begin
            int tk;
            int pidx;
            tk   = (k / (ps + 1)) % 256;
            pidx = k / per_len;
            for (int c = 0; c < NCH; c++) begin
                int du;
                du = (c == 0 && chg && pidx >= 1) ? newd : d[c];
                chk(req, 32'(pwm_out[c]), 32'(tk <= du));
            end
            if (chg && k == 5) begin
                bus_wr = 1'b1; bus_addr = 7'h00; bus_wdata = 32'(newd);
            end
            if (chg && k == 6) bus_wr = 1'b0;
            @(negedge clk);
        end
        wr(7'h50, 32'h0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        chk("R1 outputs", 32'(pwm_out), 32'h0);
        rd(7'h50, v); chk("R1 ctrl", v, 32'h0);
        for (int c = 0; c < NCH; c++) begin
            rd(7'(4 * c), v); chk("R1 duty", v, 32'h0);
        end

        // R5: duty offsets and readback.
        for (int c = 0; c < NCH; c++) wr(7'(4 * c), 32'(8'h11 * (c + 1)) | 32'hFFFF_FF00);
        for (int c = 0; c < NCH; c++) begin
            rd(7'(4 * c), v); chk("R5 duty readback", v, 32'(8'h11 * (c + 1)));
        end

        // R8: unmapped and misaligned offsets change nothing.
        wr(7'h10, 32'hAA); wr(7'h02, 32'hBB); wr(7'h4C, 32'hCC);
        for (int c = 0; c < NCH; c++) begin
            rd(7'(4 * c), v); chk("R8 unmapped write", v, 32'(8'h11 * (c + 1)));
        end
        rd(7'h50, v); chk("R8 ctrl untouched", v, 32'h0);

        // R8 and R5: only the defined control bits are stored.
        wr(7'h50, 32'hFFFF_FFFF);
        rd(7'h50, v); chk("R8 ctrl mask", v, 32'h0000_7A0F);
        wr(7'h50, 32'h0);
        @(negedge clk);
        chk("R6 disabled low", 32'(pwm_out), 32'h0);

        // R2 and R4: prescale 0, duty extremes.
        run_cfg("R4 ps0", 0, 0, 1, 128, 255, 2, 1'b0, 0);
        // R2, R4 and R7: prescale 1, deferred duty update on channel 0.
        run_cfg("R7 ps1", 1, 254, 7, 0, 200, 2, 1'b1, 3);
        // R3: prescale 18 uses both nibbles (low 2, high 1).
        run_cfg("R3 ps18", 18, 40, 255, 0, 99, 1, 1'b0, 0);

        // R6: disable in the middle of a period, then restart from zero.
        for (int c = 0; c < NCH; c++) wr(7'(4 * c), 32'd10);
        wr(7'h50, ctrl_word(0, 1'b1));
        repeat (100) @(negedge clk);
        chk("R6 mid-period low", 32'(pwm_out), 32'h0);
        wr(7'h50, 32'h0);
        for (int k = 0; k < 4; k++) begin
            chk("R6 held low", 32'(pwm_out), 32'h0);
            @(negedge clk);
        end
        run_cfg("R6 restart", 0, 10, 10, 10, 10, 1, 1'b0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule